// File: doc/BRIEF.md
# Control Transfer History Buffer

This block keeps a short, newest-first history of the control-flow transfers that a processor core reports. Each reported transfer carries a source PC, a target PC and a 3-bit kind code. A transfer is kept only when its kind is enabled in a software mask. A kept transfer becomes a record with a metadata word that holds the kind, the number of clock cycles since the previous record and a flag that says whether that count is meaningful. Records sit in a circular store. Software picks how much of the store is in use, from 16 entries up to the built maximum.

Software reaches the records through a simple port. It supplies a logical index, where 0 is the newest record, 1 the one before it, and so on. The port returns that entry combinationally and can also overwrite it. An optional stack mode follows call depth instead of history: only calls are kept, and a return removes the newest call. A clear input wipes all entries, the pointer and the cycle counter, and leaves the mode, mask and depth settings untouched.

Top module: `ctr_buffer`

## Requirements
- R1: One cycle after a qualified transfer in history mode, logical index 0 returns that transfer's source, target and kind. The metadata layout is kind in bits [2:0], elapsed count in bits [CNT_W+2:3] and count-valid in bit [CNT_W+3].
- R2: Logical index i returns the record made i records before the newest one.
- R3: Once the active depth is full, each new record in history mode replaces the oldest one. The oldest record still held sits at index depth-1.
- R4: Kind codes are 0 call, 1 return, 2 branch, 3 jump, 4 trap and 5 trap return, and enable bit k admits code k. A transfer whose enable bit is clear, or whose code is 6 or 7, changes no entry.
- R5: In stack mode only calls are recorded. A return removes the newest call, so the call before it moves to index 0. Other kinds are ignored.
- R6: In stack mode, a return that arrives when no call is held changes nothing.
- R7: The elapsed count of a record is the number of clock edges since the previous record. After reset or a clear it is one less than the number of edges since that event, and the count-valid bit is 0 for the first record made after reset or a clear. The count saturates at 2^CNT_W-1.
- R8: Reset and clear make every entry read as 0. Clear takes priority over a transfer or write in the same cycle and keeps the depth, mask and mode settings.
- R9: A depth select value s gives an active depth of min(16·2^s, MAX_DEPTH). Indices at or above the active depth read as 0, and writes to them are ignored.
- R10: A software write to an in-range index takes effect in the next cycle and changes no other entry. It is dropped in any cycle where a transfer updates the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Wipe all records, the pointer and the cycle counter |
| xfer_valid | input | 1 | A transfer is reported this cycle |
| xfer_kind | input | 3 | Transfer kind code |
| xfer_src | input | PC_W | Source PC |
| xfer_tgt | input | PC_W | Target PC |
| en_mask | input | 6 | Per-kind enable mask |
| ras_mode | input | 1 | 1 selects stack mode |
| depth_sel | input | 3 | Active depth select |
| sw_idx | input | clog2(MAX_DEPTH) | Logical index for read and write |
| sw_we | input | 1 | Write strobe for the entry at sw_idx |
| sw_wsrc | input | PC_W | Source value to write |
| sw_wtgt | input | PC_W | Target value to write |
| sw_wmeta | input | CNT_W+4 | Metadata value to write |
| rd_src | output | PC_W | Source PC of the entry at sw_idx |
| rd_tgt | output | PC_W | Target PC of the entry at sw_idx |
| rd_meta | output | CNT_W+4 | Metadata of the entry at sw_idx |

## Verification
The wipe and the recording of a new transfer can fall in the same clock edge. The bench raises clear in the same cycle as a qualified transfer and then sweeps every logical index, expecting all of them to read 0. The next record must then show a count-valid bit of 0 and a count measured from the clear edge, not from the dropped transfer. A software write that meets a transfer in the same cycle is the second collision; the bench keeps the two apart, and the rule that the write is dropped is stated in R10.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
   localparam int KIND_W    = 3;
   localparam int N_KINDS   = 6;
   localparam int DSEL_W    = 3;
   localparam int MIN_DEPTH = 16;
   localparam int MAX_LIMIT = 256;

   typedef enum logic [KIND_W-1:0] {
      KIND_CALL   = 3'd0,
      KIND_RET    = 3'd1,
      KIND_BRANCH = 3'd2,
      KIND_JUMP   = 3'd3,
      KIND_TRAP   = 3'd4,
      KIND_TRET   = 3'd5
   } xfer_kind_e;
endpackage

// File: rtl/ctr_qualify.sv
module ctr_qualify
   import ctr_pkg::*;
(
   input  logic                  valid,
   input  logic [KIND_W-1:0]     kind,
   input  logic [N_KINDS-1:0]    en_mask,
   input  logic                  ras_mode,
   input  logic                  clear,
   output logic                  push,
   output logic                  pop_req
);
   localparam int EXT_W = 1 << KIND_W;

   logic [EXT_W-1:0] mask_ext;
   logic             hit;

   assign mask_ext = {{(EXT_W-N_KINDS){1'b0}}, en_mask};
   assign hit      = valid && !clear && mask_ext[kind];
   assign push     = hit && (!ras_mode || kind == KIND_CALL);
   assign pop_req  = hit && ras_mode && kind == KIND_RET;
endmodule

// File: rtl/ctr_elapsed.sv
module ctr_elapsed #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             rec,
   output logic [CNT_W-1:0] cnt,
   output logic             ccv
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ccv <= 1'b0;
      end else if (clear) begin
         cnt <= '0;
         ccv <= 1'b0;
      end else if (rec) begin
         cnt <= CNT_W'(1);
         ccv <= 1'b1;
      end else if (cnt != CNT_MAX) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/ctr_pointer.sv
module ctr_pointer
   import ctr_pkg::*;
#(
   parameter int MAX_DEPTH = 256,
   parameter int IDX_W     = $clog2(MAX_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic              pop_req,
   input  logic [DSEL_W-1:0] depth_sel,
   output logic [IDX_W-1:0]  wptr,
   output logic [IDX_W:0]    depth,
   output logic [IDX_W-1:0]  mask,
   output logic [IDX_W:0]    occ,
   output logic              do_pop
);
   localparam int            NSEL  = $clog2(MAX_DEPTH / MIN_DEPTH) + 1;
   localparam logic [IDX_W:0] MAX_D = (IDX_W+1)'(MAX_DEPTH);
   localparam logic [IDX_W:0] MIN_D = (IDX_W+1)'(MIN_DEPTH);

   logic [IDX_W:0] occ_eff;

   always_comb begin
      if (int'(depth_sel) >= NSEL) depth = MAX_D;
      else                         depth = MIN_D << depth_sel;
   end

   assign mask    = IDX_W'(depth - 1'b1);
   assign occ_eff = (occ > depth) ? depth : occ;
   assign do_pop  = pop_req && (occ_eff != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         occ  <= '0;
      end else if (clear) begin
         wptr <= '0;
         occ  <= '0;
      end else if (push) begin
         wptr <= (wptr + 1'b1) & mask;
         occ  <= (occ_eff == depth) ? depth : occ_eff + 1'b1;
      end else if (do_pop) begin
         wptr <= (wptr - 1'b1) & mask;
         occ  <= occ_eff - 1'b1;
      end
   end
endmodule

// File: rtl/ctr_buffer.sv
module ctr_buffer
   import ctr_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int CNT_W     = 16,
   parameter int MAX_DEPTH = 256,
   parameter int IDX_W     = $clog2(MAX_DEPTH),
   parameter int META_W    = CNT_W + KIND_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               xfer_valid,
   input  logic [KIND_W-1:0]  xfer_kind,
   input  logic [PC_W-1:0]    xfer_src,
   input  logic [PC_W-1:0]    xfer_tgt,
   input  logic [N_KINDS-1:0] en_mask,
   input  logic               ras_mode,
   input  logic [DSEL_W-1:0]  depth_sel,
   input  logic [IDX_W-1:0]   sw_idx,
   input  logic               sw_we,
   input  logic [PC_W-1:0]    sw_wsrc,
   input  logic [PC_W-1:0]    sw_wtgt,
   input  logic [META_W-1:0]  sw_wmeta,
   output logic [PC_W-1:0]    rd_src,
   output logic [PC_W-1:0]    rd_tgt,
   output logic [META_W-1:0]  rd_meta
);
   initial begin
      assert (MAX_DEPTH >= MIN_DEPTH && MAX_DEPTH <= MAX_LIMIT &&
              (MAX_DEPTH & (MAX_DEPTH - 1)) == 0)
         else $fatal(1, "MAX_DEPTH must be a power of two in 16..256");
      assert (CNT_W >= 2 && PC_W >= 1)
         else $fatal(1, "CNT_W must be at least 2");
   end

   logic              push, pop_req, do_pop;
   logic [IDX_W-1:0]  wptr, mask, push_slot, pop_slot, sw_slot;
   logic [IDX_W:0]    depth, occ;
   logic [CNT_W-1:0]  cnt;
   logic              ccv, in_range, sw_wen;
   logic [META_W-1:0] rec_meta;

   logic [PC_W-1:0]   src_q  [MAX_DEPTH];
   logic [PC_W-1:0]   tgt_q  [MAX_DEPTH];
   logic [META_W-1:0] meta_q [MAX_DEPTH];

   ctr_qualify u_qual (
      .valid(xfer_valid), .kind(xfer_kind), .en_mask(en_mask),
      .ras_mode(ras_mode), .clear(clear), .push(push), .pop_req(pop_req)
   );

   ctr_pointer #(.MAX_DEPTH(MAX_DEPTH), .IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clear(clear), .push(push),
      .pop_req(pop_req), .depth_sel(depth_sel), .wptr(wptr),
      .depth(depth), .mask(mask), .occ(occ), .do_pop(do_pop)
   );

   ctr_elapsed #(.CNT_W(CNT_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .clear(clear), .rec(push),
      .cnt(cnt), .ccv(ccv)
   );

   assign rec_meta  = {ccv, cnt, xfer_kind};
   assign push_slot = wptr & mask;
   assign pop_slot  = (wptr - 1'b1) & mask;
   assign sw_slot   = (wptr - 1'b1 - sw_idx) & mask;
   assign in_range  = {1'b0, sw_idx} < depth;
   assign sw_wen    = sw_we && in_range && !clear && !push && !do_pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < MAX_DEPTH; e++) begin
            src_q[e]  <= '0;
            tgt_q[e]  <= '0;
            meta_q[e] <= '0;
         end
      end else if (clear) begin
         for (int e = 0; e < MAX_DEPTH; e++) begin
            src_q[e]  <= '0;
            tgt_q[e]  <= '0;
            meta_q[e] <= '0;
         end
      end else if (push) begin
         src_q[push_slot]  <= xfer_src;
         tgt_q[push_slot]  <= xfer_tgt;
         meta_q[push_slot] <= rec_meta;
      end else if (do_pop) begin
         src_q[pop_slot]  <= '0;
         tgt_q[pop_slot]  <= '0;
         meta_q[pop_slot] <= '0;
      end else if (sw_wen) begin
         src_q[sw_slot]  <= sw_wsrc;
         tgt_q[sw_slot]  <= sw_wtgt;
         meta_q[sw_slot] <= sw_wmeta;
      end
   end

   assign rd_src  = in_range ? src_q[sw_slot]  : '0;
   assign rd_tgt  = in_range ? tgt_q[sw_slot]  : '0;
   assign rd_meta = in_range ? meta_q[sw_slot] : '0;
endmodule

// File: rtl/ctr_buffer_chk.sv
module ctr_buffer_chk
   import ctr_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int CNT_W     = 16,
   parameter int MAX_DEPTH = 256,
   parameter int IDX_W     = $clog2(MAX_DEPTH),
   parameter int META_W    = CNT_W + KIND_W + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clear,
   input logic               xfer_valid,
   input logic [KIND_W-1:0]  xfer_kind,
   input logic [PC_W-1:0]    xfer_src,
   input logic [PC_W-1:0]    xfer_tgt,
   input logic [N_KINDS-1:0] en_mask,
   input logic               ras_mode,
   input logic [DSEL_W-1:0]  depth_sel,
   input logic [IDX_W-1:0]   sw_idx,
   input logic               sw_we,
   input logic [PC_W-1:0]    rd_src,
   input logic [PC_W-1:0]    rd_tgt,
   input logic [META_W-1:0]  rd_meta,
   input logic [IDX_W:0]     occ
);
   localparam int NSEL = $clog2(MAX_DEPTH / MIN_DEPTH) + 1;

   logic [IDX_W+1:0] act_depth;
   logic [7:0]       en_ext;
   logic             any_qual, hist_rec, empty_ret;

   always_comb begin
      if (int'(depth_sel) >= NSEL) act_depth = (IDX_W+2)'(MAX_DEPTH);
      else act_depth = (IDX_W+2)'(MIN_DEPTH * (1 << depth_sel));
   end

   assign en_ext    = {2'b00, en_mask};
   assign any_qual  = xfer_valid && en_ext[xfer_kind];
   assign hist_rec  = any_qual && !clear && !ras_mode;
   assign empty_ret = any_qual && ras_mode && xfer_kind == 3'd1 &&
                      occ == '0 && !clear && !sw_we;

   p_record_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hist_rec |=> (sw_idx != '0 ||
                    (rd_src == $past(xfer_src) && rd_tgt == $past(xfer_tgt))));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !sw_we && !any_qual) |=>
         (!$stable(sw_idx) || !$stable(depth_sel) ||
          ($stable(rd_src) && $stable(rd_tgt) && $stable(rd_meta))));

   p_empty_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
      empty_ret |=> ($stable(occ) &&
                     (!$stable(sw_idx) || !$stable(depth_sel) || $stable(rd_src))));

   p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (rd_src == '0 && rd_tgt == '0 && rd_meta == '0));

   p_out_of_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ({2'b00, sw_idx} >= act_depth) |->
         (rd_src == '0 && rd_tgt == '0 && rd_meta == '0));
endmodule

bind ctr_buffer ctr_buffer_chk #(
   .PC_W(PC_W), .CNT_W(CNT_W), .MAX_DEPTH(MAX_DEPTH), .IDX_W(IDX_W), .META_W(META_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clear(clear), .xfer_valid(xfer_valid),
   .xfer_kind(xfer_kind), .xfer_src(xfer_src), .xfer_tgt(xfer_tgt),
   .en_mask(en_mask), .ras_mode(ras_mode), .depth_sel(depth_sel),
   .sw_idx(sw_idx), .sw_we(sw_we), .rd_src(rd_src), .rd_tgt(rd_tgt),
   .rd_meta(rd_meta), .occ(occ)
);

// File: tb/ctr_buffer_bench.sv
`timescale 1ns/1ps
module ctr_buffer_bench;
   localparam int PC_W = 16, CNT_W = 4, MAXD = 32, IDX_W = 5, META_W = 8;
   localparam int CMAX = 15;

   logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, xfer_valid = 1'b0;
   logic ras_mode = 1'b0, sw_we = 1'b0;
   logic [2:0] xfer_kind = '0, depth_sel = '0;
   logic [PC_W-1:0] xfer_src = '0, xfer_tgt = '0, sw_wsrc = '0, sw_wtgt = '0;
   logic [5:0] en_mask = 6'h3F;
   logic [IDX_W-1:0] sw_idx = '0;
   logic [META_W-1:0] sw_wmeta = '0;
   logic [PC_W-1:0] rd_src, rd_tgt;
   logic [META_W-1:0] rd_meta;

   int nchk = 0, nfail = 0, ec = 0;
   int ref_e = 0, ref_off = 1, seen = 0, h_n = 0;
   bit done = 0;
   logic [PC_W-1:0]   h_src  [64];
   logic [PC_W-1:0]   h_tgt  [64];
   logic [META_W-1:0] h_meta [64];

   ctr_buffer #(.PC_W(PC_W), .CNT_W(CNT_W), .MAX_DEPTH(MAXD)) u_ctr_buffer (
      .clk(clk), .rst_n(rst_n), .clear(clear), .xfer_valid(xfer_valid),
      .xfer_kind(xfer_kind), .xfer_src(xfer_src), .xfer_tgt(xfer_tgt),
      .en_mask(en_mask), .ras_mode(ras_mode), .depth_sel(depth_sel),
      .sw_idx(sw_idx), .sw_we(sw_we), .sw_wsrc(sw_wsrc), .sw_wtgt(sw_wtgt),
      .sw_wmeta(sw_wmeta), .rd_src(rd_src), .rd_tgt(rd_tgt), .rd_meta(rd_meta)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) ec <= ec + 1;

   function automatic int mdepth();
      return (depth_sel >= 3'd2) ? MAXD : (16 << depth_sel);
   endfunction

   function automatic void m_clear();
      for (int i = 0; i < 64; i++) begin
         h_src[i] = '0; h_tgt[i] = '0; h_meta[i] = '0;
      end
      h_n = 0;
   endfunction

   function automatic void m_push(logic [PC_W-1:0] s, logic [PC_W-1:0] t, logic [2:0] k);
      int c;
      c = ec - ref_e - ref_off;
      if (c > CMAX) c = CMAX;
      for (int i = 63; i > 0; i--) begin
         h_src[i] = h_src[i-1]; h_tgt[i] = h_tgt[i-1]; h_meta[i] = h_meta[i-1];
      end
      h_src[0] = s; h_tgt[0] = t; h_meta[0] = {seen[0], c[3:0], k};
      h_n = (h_n + 1 > mdepth()) ? mdepth() : h_n + 1;
      ref_e = ec; ref_off = 0; seen = 1;
   endfunction

   function automatic void m_pop();
      for (int i = 0; i < 63; i++) begin
         h_src[i] = h_src[i+1]; h_tgt[i] = h_tgt[i+1]; h_meta[i] = h_meta[i+1];
      end
      h_n = h_n - 1;
      h_src[h_n] = '0; h_tgt[h_n] = '0; h_meta[h_n] = '0;
   endfunction

   task automatic step(input bit v, input logic [2:0] k, input logic [PC_W-1:0] s,
                       input logic [PC_W-1:0] t, input bit clr);
      bit q;
      xfer_valid = v; xfer_kind = k; xfer_src = s; xfer_tgt = t; clear = clr;
      @(negedge clk);
      q = v && k < 3'd6 && en_mask[k];
      if (clr) begin
         m_clear(); ref_e = ec; ref_off = 1; seen = 0;
      end else if (q) begin
         if (!ras_mode) m_push(s, t, k);
         else if (k == 3'd0) m_push(s, t, k);
         else if (k == 3'd1 && h_n > 0) m_pop();
      end
      xfer_valid = 1'b0; clear = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, '0, 1'b0);
   endtask

   task automatic sw_write(input int idx, input logic [PC_W-1:0] s,
                           input logic [PC_W-1:0] t, input logic [META_W-1:0] m);
      sw_idx = IDX_W'(idx); sw_wsrc = s; sw_wtgt = t; sw_wmeta = m; sw_we = 1'b1;
      @(negedge clk);
      sw_we = 1'b0;
      if (idx < mdepth() && idx < h_n) begin
         h_src[idx] = s; h_tgt[idx] = t; h_meta[idx] = m;
      end
   endtask

   task automatic chk(input int idx, input string tag);
      logic [PC_W-1:0] es, et;
      logic [META_W-1:0] em;
      bit hit;
      sw_idx = IDX_W'(idx);
      #0.5;
      hit = idx < mdepth() && idx < h_n;
      es = hit ? h_src[idx] : '0;
      et = hit ? h_tgt[idx] : '0;
      em = hit ? h_meta[idx] : '0;
      nchk++;
      if (rd_src !== es || rd_tgt !== et || rd_meta !== em) begin
         nfail++;
         $display("FAIL %s idx %0d: got src=%h tgt=%h meta=%h, expected src=%h tgt=%h meta=%h",
                  tag, idx, rd_src, rd_tgt, rd_meta, es, et, em);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int i = 0; i < MAXD; i++) chk(i, tag);
   endtask

   initial begin
      m_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      ref_e = ec; ref_off = 1; seen = 0;
      chk_all("R8 reset");

      // R1 R2 R3: history mode, 20 records into depth 16, uneven gaps
      for (int n = 0; n < 20; n++) begin
         step(1'b1, 3'(n % 6), 16'h1000 + 16'(n), 16'h2000 + 16'(n * 3), 1'b0);
         idle(n % 3);
      end
      chk_all("R1 R2 R3");

      // R4: disabled kind and unused codes
      en_mask = 6'b111110;
      step(1'b1, 3'd0, 16'hDEAD, 16'hBEEF, 1'b0);
      en_mask = 6'h3F;
      step(1'b1, 3'd6, 16'hAAAA, 16'hBBBB, 1'b0);
      step(1'b1, 3'd7, 16'hCCCC, 16'hDDDD, 1'b0);
      chk_all("R4");

      // R9: write beyond active depth is ignored
      sw_write(20, 16'h5555, 16'h6666, 8'h77);
      chk_all("R9 ignored write");

      // R10: in-range write
      sw_write(3, 16'h1234, 16'h5678, 8'h9A);
      chk_all("R10");

      // R7: saturation, then back-to-back count of 1
      idle(20);
      step(1'b1, 3'd2, 16'h3000, 16'h3001, 1'b0);
      chk(0, "R7 saturate");
      step(1'b1, 3'd3, 16'h3002, 16'h3003, 1'b0);
      chk(0, "R7 adjacent");
      chk(1, "R7 saturate kept");

      // R8: clear wins over a same-cycle transfer
      step(1'b1, 3'd0, 16'h4000, 16'h4001, 1'b1);
      chk_all("R8 clear vs transfer");
      idle(2);
      step(1'b1, 3'd4, 16'h4100, 16'h4101, 1'b0);
      chk(0, "R7 first after clear");
      for (int n = 0; n < 17; n++) step(1'b1, 3'd2, 16'h4200 + 16'(n), 16'h4300, 1'b0);
      chk_all("R8 depth kept");

      // R9: larger depth and capped select
      depth_sel = 3'd1;
      step(1'b0, 3'd0, '0, '0, 1'b1);
      for (int n = 0; n < 40; n++) step(1'b1, 3'd3, 16'h5000 + 16'(n), 16'h6000 - 16'(n), 1'b0);
      chk_all("R9 depth 32");
      depth_sel = 3'd5;
      chk_all("R9 capped");

      // R5 R6: stack mode
      depth_sel = 3'd0;
      step(1'b0, 3'd0, '0, '0, 1'b1);
      ras_mode = 1'b1;
      step(1'b1, 3'd0, 16'h7001, 16'h7101, 1'b0);
      step(1'b1, 3'd0, 16'h7002, 16'h7102, 1'b0);
      step(1'b1, 3'd0, 16'h7003, 16'h7103, 1'b0);
      step(1'b1, 3'd2, 16'h7004, 16'h7104, 1'b0);
      step(1'b1, 3'd4, 16'h7005, 16'h7105, 1'b0);
      chk_all("R5 calls only");
      step(1'b1, 3'd1, 16'h7006, 16'h7106, 1'b0);
      chk_all("R5 return pops");
      step(1'b1, 3'd1, 16'h7007, 16'h7107, 1'b0);
      step(1'b1, 3'd1, 16'h7008, 16'h7108, 1'b0);
      step(1'b1, 3'd1, 16'h7009, 16'h7109, 1'b0);
      chk_all("R6 empty return");
      step(1'b1, 3'd0, 16'h700A, 16'h710A, 1'b0);
      chk_all("R6 call after empty");
      ras_mode = 1'b0;

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule